// File: doc/BRIEF.md
# Telemetry Alarm Qualifier

This block turns a stream of raw sensor readings into alarm and warning flags that a management register map can trust. Each accepted reading first goes through a moving-average filter with a selectable length. The filtered value is then judged by four independent level qualifiers: high alarm, high warning, low warning and low alarm. Each qualifier has its own trip level and its own release level, which gives hysteresis. A flag changes state only after a programmable number of consecutive filtered readings have stayed past the level being tested.

Any flag change raises a one-cycle notification pulse. The pulse is rate-limited, so a sensor that keeps oscillating cannot flood the host. A change that arrives inside the quiet interval is held as pending and is reported once the interval has run out. Each flag can also be set to latch. A latched status bit stays set after its condition goes away, until the host clears it with a write-one-to-clear pulse.

The sample input is a valid/ready stream. The block never applies back-pressure: `s_ready` is high whenever reset is released, and every cycle with `s_valid` high delivers one reading. The thresholds, dwell count, interval, window select and latch enables are plain control inputs. They are expected to stay stable while readings are flowing.

Top module: `telemetry_alarm_qual`

## Requirements
- R1: `s_ready` is high in every cycle out of reset, and each cycle with `s_valid` high consumes exactly one reading from `s_data`.
- R2: The filtered value is the truncated mean of the newest 1, 2, 4 or 8 accepted readings, for `win_sel` values 0, 1, 2 and 3. History entries not yet written since reset count as zero.
- R3: A high-side flag (bit 0 high alarm, bit 1 high warning) sets after `dwell` consecutive filtered values at or above its trip level. It clears after `dwell` consecutive filtered values at or below its release level.
- R4: A low-side flag (bit 2 low warning, bit 3 low alarm) sets after `dwell` consecutive filtered values at or below its trip level. It clears after `dwell` consecutive filtered values at or above its release level.
- R5: One filtered value that is not past the level being tested restarts the dwell count. A `dwell` of 0 behaves as 1.
- R6: Flags change only in response to accepted readings. A reading accepted at clock edge k is reflected in `flags_o` after edge k+1.
- R7: Every flag change leads to a one-cycle `notify_o` pulse. Two pulses are never closer together than `rate_iv`+1 clock cycles.
- R8: A change that falls inside the quiet interval is kept pending and still produces one pulse when the interval ends. When `rate_iv` is 0, each change is reported without delay.
- R9: When bit i of `latch_en` is high and flag i is set, `latched_o[i]` becomes 1 and stays 1 after the flag clears. When bit i is low, `latched_o[i]` remains 0.
- R10: A `latch_clr[i]` pulse clears `latched_o[i]` only if flag i is 0 at that time. A clear pulse while the flag is set has no effect.
- R11: After reset, `flags_o`, `latched_o` and `notify_o` are all 0, and the filter history is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Reading valid |
| s_ready | output | 1 | Reading accepted (always high out of reset) |
| s_data | input | DW | Unsigned sensor reading |
| win_sel | input | 2 | Filter length select: 1, 2, 4 or 8 readings |
| trip_lvl | input | 4*DW | Trip levels, DW bits per flag, flag i at bits i*DW upward |
| clr_lvl | input | 4*DW | Release levels, same packing |
| dwell | input | DWELL_W | Consecutive filtered values needed to change a flag |
| rate_iv | input | RATE_W | Quiet interval between notifications, in cycles |
| latch_en | input | 4 | Per-flag latch enable |
| latch_clr | input | 4 | Per-flag write-one-to-clear pulse |
| flags_o | output | 4 | Qualified flags: high alarm, high warning, low warning, low alarm |
| notify_o | output | 1 | One-cycle change notification |
| latched_o | output | 4 | Latched flag status |

## Verification
Several properties are checked on every cycle. A flag holds its value when no filtered value arrives, and a flag only rises or falls right after a filtered value has crossed its trip or release level. No notification fires before the interval loaded at the previous one has elapsed, and a change that is not reported immediately always leaves a pending mark. A latch bit is set whenever its flag and enable are high, and it drops only on a clear pulse while its flag is low. Other behaviour is shown only by the bench's scenarios: exact filter arithmetic across window lengths, the dwell restart, the exact-boundary cases, the number of pulses delivered under rapid toggling, and the final pending report.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int NUM_LVL  = 4;   // high alarm, high warning, low warning, low alarm
  localparam int NUM_HIGH = 2;   // first NUM_HIGH flags test the high side
  localparam int WIN_MAX  = 8;   // longest averaging window
  localparam int WSEL_W   = $clog2($clog2(WIN_MAX) + 1);
  typedef logic [NUM_LVL-1:0] lvl_vec_t;
endpackage

// File: rtl/tlm_avg_filter.sv
module tlm_avg_filter
  import tlm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [DW-1:0]     in_d,
  input  logic [WSEL_W-1:0] win_sel,
  output logic              out_v,
  output logic [DW-1:0]     out_d
);
  localparam int PRIOR = WIN_MAX - 1;
  localparam int SW    = DW + $clog2(WIN_MAX);

  logic [DW-1:0] hist [PRIOR];
  logic [SW-1:0] acc;

  always_comb begin
    acc = SW'(in_d);
    for (int j = 0; j < PRIOR; j++) begin
      if (j < (1 << win_sel) - 1) acc = acc + SW'(hist[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < PRIOR; j++) hist[j] <= '0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        hist[0] <= in_d;
        for (int j = 1; j < PRIOR; j++) hist[j] <= hist[j-1];
        out_d <= DW'(acc >> win_sel);
      end
    end
  end

  // R2: a one-reading window passes the reading straight through
  a_r2_unit_window: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && win_sel == '0) |=> (out_v && out_d == $past(in_d)));
endmodule

// File: rtl/tlm_level_qual.sv
module tlm_level_qual #(
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter bit HIGH_SIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] trip,
  input  logic [DW-1:0] rel,
  input  logic [CW-1:0] dwell,
  output logic          flag_o,
  output logic          chg_o
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] need;
  logic [CW:0]   cnt_nx;
  logic          past_trip, past_rel, beyond;

  assign need      = (dwell == '0) ? CW'(1) : dwell;
  assign cnt_nx    = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign past_trip = HIGH_SIDE ? (a >= trip) : (a <= trip);
  assign past_rel  = HIGH_SIDE ? (a <= rel)  : (a >= rel);
  assign beyond    = flag_o ? past_rel : past_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      chg_o  <= 1'b0;
      cnt    <= '0;
    end else begin
      chg_o <= 1'b0;
      if (v) begin
        if (beyond) begin
          if (cnt_nx >= {1'b0, need}) begin
            flag_o <= ~flag_o;
            chg_o  <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  // R6: no filtered value, no flag movement
  a_r6_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !v |=> $stable(flag_o));

  generate
    if (HIGH_SIDE) begin : g_hi
      // R3: rising needs a value at or above trip, falling needs one at or below release
      a_r3_rise_at_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(v && a >= trip));
      a_r3_fall_at_rel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(v && a <= rel));
    end else begin : g_lo
      // R4: mirrored comparisons for the low side
      a_r4_rise_at_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(v && a <= trip));
      a_r4_fall_at_rel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(v && a >= rel));
    end
  endgenerate
endmodule

// File: rtl/tlm_notify_limiter.sv
module tlm_notify_limiter #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [RATE_W-1:0] rate_iv,
  output logic              pulse_o
);
  logic [RATE_W-1:0] timer;
  logic              pend;
  logic              fire;

  assign fire = (evt || pend) && (timer == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer   <= '0;
      pend    <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire;
      if (fire) begin
        timer <= rate_iv;
        pend  <= 1'b0;
      end else begin
        if (timer != '0) timer <= timer - 1'b1;
        if (evt) pend <= 1'b1;
      end
    end
  end

  // Checker state: cycles since the last report and the interval loaded then
  logic [RATE_W:0]   since;
  logic [RATE_W-1:0] last_iv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since   <= '0;
      last_iv <= '0;
    end else if (fire) begin
      since   <= '0;
      last_iv <= rate_iv;
    end else if (since != {(RATE_W+1){1'b1}}) begin
      since <= since + 1'b1;
    end
  end

  // R7: a report never comes before the quiet interval has elapsed
  a_r7_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (since >= {1'b0, last_iv}));
  // R8: an unreported change is remembered
  a_r8_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !fire) |=> pend);
endmodule

// File: rtl/tlm_alarm_latch.sv
module tlm_alarm_latch
  import tlm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_vec_t flag,
  input  lvl_vec_t en,
  input  lvl_vec_t clr,
  output lvl_vec_t latched_o
);
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latched_o[i] <= 1'b0;
      else latched_o[i] <= (latched_o[i] & ~(clr[i] & ~flag[i])) | (flag[i] & en[i]);
    end

    // R9: an enabled, present condition is captured
    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && en[i]) |=> latched_o[i]);
    // R10: release only through a clear while the condition is gone
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latched_o[i]) |-> $past(clr[i] && !flag[i]));
  end
endmodule

// File: rtl/telemetry_alarm_qual.sv
module telemetry_alarm_qual
  import tlm_pkg::*;
#(
  parameter int DW      = 16,
  parameter int DWELL_W = 8,
  parameter int RATE_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [DW-1:0]         s_data,
  input  logic [WSEL_W-1:0]     win_sel,
  input  logic [NUM_LVL*DW-1:0] trip_lvl,
  input  logic [NUM_LVL*DW-1:0] clr_lvl,
  input  logic [DWELL_W-1:0]    dwell,
  input  logic [RATE_W-1:0]     rate_iv,
  input  logic [NUM_LVL-1:0]    latch_en,
  input  logic [NUM_LVL-1:0]    latch_clr,
  output logic [NUM_LVL-1:0]    flags_o,
  output logic                  notify_o,
  output logic [NUM_LVL-1:0]    latched_o
);
  logic          avg_v;
  logic [DW-1:0] avg_d;
  lvl_vec_t      flag_w, chg_w;

  assign s_ready = rst_n;

  tlm_avg_filter #(.DW(DW)) u_filt (
    .clk(clk), .rst_n(rst_n),
    .in_v(s_valid & s_ready), .in_d(s_data), .win_sel(win_sel),
    .out_v(avg_v), .out_d(avg_d)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    tlm_level_qual #(.DW(DW), .CW(DWELL_W), .HIGH_SIDE(g < NUM_HIGH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .v(avg_v), .a(avg_d),
      .trip(trip_lvl[g*DW +: DW]), .rel(clr_lvl[g*DW +: DW]),
      .dwell(dwell),
      .flag_o(flag_w[g]), .chg_o(chg_w[g])
    );
  end

  tlm_notify_limiter #(.RATE_W(RATE_W)) u_ntf (
    .clk(clk), .rst_n(rst_n), .evt(|chg_w), .rate_iv(rate_iv), .pulse_o(notify_o)
  );

  tlm_alarm_latch u_lat (
    .clk(clk), .rst_n(rst_n), .flag(flag_w), .en(latch_en), .clr(latch_clr),
    .latched_o(latched_o)
  );

  assign flags_o = flag_w;

  // R1: the stream never stalls once out of reset
  a_r1_always_ready: assert property (@(posedge clk) disable iff (!rst_n) s_ready);
endmodule

// File: tb/telemetry_alarm_qual_test.sv
`timescale 1ns/1ps
module telemetry_alarm_qual_test;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic [DW-1:0] s_data = '0;
  logic [1:0] win_sel = 2'd3;
  logic [4*DW-1:0] trip_lvl, clr_lvl;
  logic [7:0] dwell = 8'd1;
  logic [15:0] rate_iv = 16'd0;
  logic [3:0] latch_en = 4'd0, latch_clr = 4'd0;
  logic [3:0] flags_o, latched_o;
  logic notify_o;

  telemetry_alarm_qual uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .win_sel(win_sel), .trip_lvl(trip_lvl), .clr_lvl(clr_lvl), .dwell(dwell),
    .rate_iv(rate_iv), .latch_en(latch_en), .latch_clr(latch_clr),
    .flags_o(flags_o), .notify_o(notify_o), .latched_o(latched_o)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int trip_m [4] = '{900, 800, 200, 100};
  int rel_m  [4] = '{850, 760, 240, 140};
  int hist_m [7];
  bit flg_m [4];
  int cnt_m [4];

  int cyc = 0, npulse = 0, last_p = -1, min_sp = 1000000;
  always @(negedge clk) begin
    cyc++;
    if (notify_o) begin
      npulse++;
      if (last_p >= 0 && cyc - last_p < min_sp) min_sp = cyc - last_p;
      last_p = cyc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_avg(input int d);
    int s = d;
    for (int j = 0; j < (1 << win_sel) - 1; j++) s += hist_m[j];
    return s >> win_sel;
  endfunction

  function automatic int m_flags();
    int r = 0;
    for (int i = 0; i < 4; i++) if (flg_m[i]) r |= (1 << i);
    return r;
  endfunction

  task automatic m_step(input int d);
    int a = m_avg(d);
    int need = (dwell == 0) ? 1 : int'(dwell);
    for (int j = 6; j > 0; j--) hist_m[j] = hist_m[j-1];
    hist_m[0] = d;
    for (int i = 0; i < 4; i++) begin
      bit hi = (i < 2);
      bit bey;
      if (flg_m[i]) bey = hi ? (a <= rel_m[i]) : (a >= rel_m[i]);
      else          bey = hi ? (a >= trip_m[i]) : (a <= trip_m[i]);
      if (bey) begin
        if (cnt_m[i] + 1 >= need) begin flg_m[i] = !flg_m[i]; cnt_m[i] = 0; end
        else cnt_m[i]++;
      end else cnt_m[i] = 0;
    end
  endtask

  // One reading; checks flags against the model (R3/R4 through the model)
  task automatic send(input int d, input string req);
    @(negedge clk); s_valid = 1'b1; s_data = DW'(d);
    @(negedge clk); s_valid = 1'b0; s_data = 16'hBEEF;
    repeat (2) @(negedge clk);
    m_step(d);
    check(req, int'(flags_o), m_flags());
  endtask

  task automatic pulse_clr(input logic [3:0] c);
    @(negedge clk); latch_clr = c;
    @(negedge clk); latch_clr = 4'd0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin
      trip_lvl[i*DW +: DW] = DW'(trip_m[i]);
      clr_lvl[i*DW +: DW]  = DW'(rel_m[i]);
      flg_m[i] = 0; cnt_m[i] = 0;
    end
    for (int j = 0; j < 7; j++) hist_m[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R1 ready
    check("R11 flags", int'(flags_o), 0);
    check("R11 latched", int'(latched_o), 0);
    check("R11 notify", int'(notify_o), 0);
    check("R1 ready", int'(s_ready), 1);

    // R2 / R11: zero history, 8-window: 7200/8 = 900 reaches high alarm trip exactly
    send(7200, "R2 zero-history mean");
    check("R2 exact trip via mean", int'(flags_o), 4'b0011);

    // R3 hysteresis, window 1
    win_sel = 2'd0;
    send(870, "R3 above release");
    check("R3 alarm held above release", int'(flags_o[0]), 1);
    send(850, "R3 at release");
    check("R3 alarm released at level", int'(flags_o), 4'b0010);
    send(500, "R3 warn clear");

    // R4 low side
    send(200, "R4 low warn trip");
    check("R4 low warn", int'(flags_o), 4'b0100);
    send(230, "R4 within band");
    check("R4 low warn held", int'(flags_o), 4'b0100);
    send(240, "R4 release");
    check("R4 low warn cleared", int'(flags_o), 4'b0000);

    // R5 dwell restart
    dwell = 8'd3;
    send(950, "R5 a"); send(950, "R5 b"); send(500, "R5 break");
    send(950, "R5 c"); send(950, "R5 d");
    check("R5 not yet set", int'(flags_o[0]), 0);
    send(950, "R5 e");
    check("R5 set after dwell", int'(flags_o[0]), 1);
    dwell = 8'd0;
    send(500, "R5 dwell0 acts as 1");
    check("R5 dwell0 clear", int'(flags_o[0]), 0);

    // R2 four-reading window
    dwell = 8'd1; win_sel = 2'd2;
    for (int k = 0; k < 4; k++) send(500, "R2 fill");
    send(1300, "R2 mean 700");
    check("R2 mean below trip", int'(flags_o[0]), 0);
    send(1300, "R2 mean 900");
    check("R2 mean at trip", int'(flags_o[0]), 1);
    win_sel = 2'd0;
    send(500, "R2 back");

    // R6 no valid, no change
    @(negedge clk); s_data = 16'd5000;
    repeat (6) @(negedge clk);
    check("R6 ignored without valid", int'(flags_o), m_flags());

    // R9 / R10 latch
    latch_en = 4'b0001;
    send(1000, "R9 set");
    check("R9 latched", int'(latched_o), 4'b0001);
    pulse_clr(4'b0001);
    check("R10 clear ignored while set", int'(latched_o), 4'b0001);
    send(500, "R9 condition gone");
    check("R9 stays latched", int'(latched_o), 4'b0001);
    pulse_clr(4'b0001);
    check("R10 cleared", int'(latched_o), 4'b0000);
    latch_en = 4'd0;

    // R7 / R8 rate limit under rapid toggling
    rate_iv = 16'd40;
    repeat (50) @(negedge clk);
    npulse = 0; last_p = -1; min_sp = 1000000;
    for (int k = 0; k < 20; k++) send((k % 2 == 0) ? 1000 : 500, "R7 toggle");
    begin
      int stim_end = cyc;
      repeat (60) @(negedge clk);
      check("R7 min spacing ok", int'(min_sp >= 41), 1);
      check("R7 limited count", int'(npulse >= 2 && npulse <= 4), 1);
      check("R8 pending reported", int'(last_p >= stim_end - 2), 1);
    end

    // R8 no limit when interval is 0
    rate_iv = 16'd0;
    npulse = 0;
    for (int k = 0; k < 8; k++) send((k % 2 == 0) ? 1000 : 500, "R8 toggle");
    repeat (4) @(negedge clk);
    check("R8 every change reported", npulse, 8);

    // Random readings against the model (R3, R4, R5, R2)
    for (int blk = 0; blk < 6; blk++) begin
      win_sel = 2'($urandom_range(0, 3));
      dwell = 8'($urandom_range(0, 3));
      for (int k = 0; k < 50; k++) send(int'($urandom_range(0, 1100)), "R3 R4 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule